// File: doc/BRIEF.md
# Quarter-Wave Sine and Cosine Lookup

This block turns a 16-bit phase word into a pair of 16-bit two's complement samples, sine and cosine, delivered together on the same clock. Only the first quadrant of a sine period is kept in a table. The other three quadrants are rebuilt from it. The second-highest phase bit reflects the table address, and the highest phase bit flips the sign of the sample. The cosine lane is the sine lane fed with the phase advanced by a quarter turn.

The table is filled at elaboration time from a constant function. Each entry holds the sine of its exact grid angle, so a phase of zero gives an output of exactly zero. The end of each quadrant, where the reflected address runs one past the table, is served by a dedicated peak value.

The parameter `LUT_BITS` (16, 12 or 8) sets how many of the top phase bits are used. With `LUT_BITS` = L, the table has 2^(L-2) entries of L-1 bits. The magnitude is left-justified into the 16-bit output. A clock enable stalls the whole two-stage pipeline. In a synthesizer, the enable is normally shared with the phase accumulator that drives this block.

Top module: `quad_sincos_rom`

## Requirements
- R1: With L = `LUT_BITS`, k = phase_i[15:16-L] and Mx = 2^(L-1)-1, the value of sin_o is m << (16-L), where m = round(Mx·|sin(2πk/2^L)|). This value is negated in two's complement when k ≥ 2^(L-1), which means phase bit 15 is set.
- R2: cos_o follows the R1 formula with k replaced by (k + 2^(L-2)) mod 2^L. It is produced in the same cycle as sin_o, for the same input phase.
- R3: Phase bits below the top L bits have no effect on either output.
- R4: With en_i high, a phase presented before a rising edge appears on the outputs after the second rising edge.
- R5: While en_i is low, both outputs and the sample held inside the pipeline keep their values. When en_i returns high, the sample that was in flight is the next one delivered.
- R6: rst_n is an asynchronous active-low reset. While it is low, sin_o and cos_o read 0x0000.
- R7: The waveform is symmetric about zero. Neither output ever takes the value 0x8000, and adding half a turn to the phase negates the sample exactly.
- R8: Let P = Mx << (16-L), which is 0x7FFF when L = 16. Phase 0x0000 gives sine 0 and cosine P. Phase 0x4000 gives sine P and cosine 0. Phase 0x8000 gives sine 0 and cosine -P.
- R9: When L < 16, the low 16-L bits of both outputs are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; low stalls the pipeline |
| phase_i | input | 16 | Unsigned phase, full turn = 2^16 |
| sin_o | output | 16 | Sine sample, two's complement |
| cos_o | output | 16 | Cosine sample, two's complement |

## Verification
A wrong table entry or a wrong address reflection shows up as a single wrong sample, two cycles after the offending phase is presented. Such an error only appears for the phases that reach that entry, so every phase is swept through the pipeline. An error in the sign stage or the quadrant logic instead corrupts a whole quarter or half of the period. It breaks the exact anchor values and the half-turn negation at once. A stall that leaks shows as an output that moves while the enable is low. It also shows as a lost sample once the enable returns.

// File: rtl/quad_sincos_rom.sv
module quad_sincos_rom #(
  parameter int LUT_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic [15:0] phase_i,
  output logic [15:0] sin_o,
  output logic [15:0] cos_o
);
  localparam int AW    = LUT_BITS - 2;
  localparam int DEPTH = 1 << AW;
  localparam int MW    = LUT_BITS - 1;
  localparam int SH    = 16 - LUT_BITS;
  localparam int MAXV  = (1 << MW) - 1;
  localparam logic [MW-1:0] MAXMAG = MW'(MAXV);
  localparam logic [15:0]   PEAK   = 16'(MAXV) << SH;

  function automatic real qsin(input real x);
    real t, s;
    t = x;
    s = x;
    for (int n = 1; n < 12; n++) begin
      t = -t * x * x / real'((2 * n) * (2 * n + 1));
      s = s + t;
    end
    return s;
  endfunction

  function automatic logic [MW-1:0] entry(input int i);
    real x;
    int  v;
    x = 3.14159265358979323846 * real'(i) / real'(2 * DEPTH);
    v = $rtoi(real'(MAXV) * qsin(x) + 0.5);
    return MW'(v);
  endfunction

  logic [MW-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam logic [MW-1:0] VAL = entry(i);
    assign rom[i] = VAL;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_lane
    logic [15:0]         ph;
    logic [LUT_BITS-1:0] k;
    logic [AW:0]         ext;
    logic [MW-1:0]       mag;
    logic [MW-1:0]       mag_q;
    logic                neg_q;
    logic [15:0]         mag16;
    logic [15:0]         out_q;
    logic                unused_lo;

    assign ph        = (ch == 0) ? phase_i : phase_i + 16'h4000;
    assign unused_lo = ^ph;
    assign k         = ph[15 -: LUT_BITS];
    assign ext       = k[AW] ? ({1'b0, ~k[AW-1:0]} + 1'b1) : {1'b0, k[AW-1:0]};
    assign mag       = ext[AW] ? MAXMAG : rom[ext[AW-1:0]];
    assign mag16     = 16'(mag_q) << SH;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mag_q <= '0;
        neg_q <= 1'b0;
        out_q <= '0;
      end else if (en_i) begin
        mag_q <= mag;
        neg_q <= k[LUT_BITS-1];
        out_q <= neg_q ? (16'd0 - mag16) : mag16;
      end
    end

    if (ch == 0) begin : g_s
      assign sin_o = out_q;
    end else begin : g_c
      assign cos_o = out_q;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age <= '0;
    else if (age != 2'd3)    age <= age + 2'd1;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(sin_o) && $stable(cos_o)));

  p_no_minneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_o != 16'h8000) && (cos_o != 16'h8000));

  p_anchor_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(en_i) && $past(en_i, 2) && $past(phase_i, 2) == 16'h0000)
    |-> (sin_o == 16'h0000 && cos_o == PEAK));

  p_anchor_quarter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(en_i) && $past(en_i, 2) && $past(phase_i, 2) == 16'h4000)
    |-> (sin_o == PEAK && cos_o == 16'h0000));

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(en_i) && $past(en_i, 2) && $past(phase_i[15], 2))
    |-> (sin_o == 16'h0000 || sin_o[15]));

  if (SH > 0) begin : g_lowchk
    p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sin_o[SH-1:0] == '0) && (cos_o[SH-1:0] == '0));
  end
endmodule

// File: tb/test_quad_sincos_rom.sv
`timescale 1ns/1ps
module test_quad_sincos_rom;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] phase_i = '0;
  logic [15:0] sin_a, cos_a, sin_b, cos_b;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_sincos_rom #(.LUT_BITS(12)) i_quad_sincos_rom (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .phase_i(phase_i), .sin_o(sin_a), .cos_o(cos_a));
  quad_sincos_rom #(.LUT_BITS(8)) i_quad_sincos_rom_l8 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .phase_i(phase_i), .sin_o(sin_b), .cos_o(cos_b));

  function automatic logic [15:0] expv(input int L, input logic [15:0] ph, input bit cosf);
    int sh, k, n, mx, m;
    real v;
    logic [15:0] r;
    sh = 16 - L;
    n  = 1 << L;
    k  = int'(ph) >> sh;
    if (cosf) k = (k + n / 4) % n;
    v  = $sin(2.0 * 3.14159265358979323846 * real'(k) / real'(n));
    mx = (1 << (L - 1)) - 1;
    m  = $rtoi(((v < 0.0) ? -v : v) * real'(mx) + 0.5);
    r  = 16'(m << sh);
    return (k >= n / 2) ? 16'(16'd0 - r) : r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [15:0] ph);
    chk({req, " sin12"}, sin_a, expv(12, ph, 1'b0));
    chk({req, " cos12"}, cos_a, expv(12, ph, 1'b1));
    chk({req, " sin8"},  sin_b, expv(8,  ph, 1'b0));
    chk({req, " cos8"},  cos_b, expv(8,  ph, 1'b1));
  endtask

  task automatic push(input logic [15:0] ph, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      phase_i = ph;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] p1, p2, cur, low_a;
    p1 = '0;
    p2 = '0;
    @(negedge clk);
    chk("R6 reset sin12", sin_a, 16'h0000);
    chk("R6 reset cos12", cos_a, 16'h0000);
    chk("R6 reset sin8",  sin_b, 16'h0000);
    chk("R6 reset cos8",  cos_b, 16'h0000);
    rst_n = 1'b1;
    en_i  = 1'b1;

    // R8 anchors
    push(16'h0000, 3);
    chk("R8 p0 sin", sin_a, 16'h0000);  chk("R8 p0 cos", cos_a, 16'h7FF0);
    chk("R8 p0 cos8", cos_b, 16'h7F00);
    push(16'h4000, 3);
    chk("R8 q sin", sin_a, 16'h7FF0);   chk("R8 q cos", cos_a, 16'h0000);
    push(16'h8000, 3);
    chk("R8 h sin", sin_a, 16'h0000);   chk("R8 h cos", cos_a, 16'h8010);
    chk("R8 h cos8", cos_b, 16'h8100);

    // R4 latency: single change from 0 to a quarter turn
    push(16'h0000, 3);
    phase_i = 16'h4000;
    @(negedge clk);
    phase_i = 16'h0000;
    chk("R4 one edge sin", sin_a, 16'h0000);
    @(negedge clk);
    chk("R4 two edges sin", sin_a, 16'h7FF0);

    // R1 R2 R7 R9 sweep of every phase in scrambled order
    for (int i = 0; i < 65538; i++) begin
      if (i >= 2) begin
        chk_all("R1/R2 sweep", p2);
        n_cmp++;
        if (sin_a == 16'h8000 || cos_a == 16'h8000 || sin_b == 16'h8000 || cos_b == 16'h8000) begin
          n_bad++;
          $display("FAIL R7 min-neg seen actual=%h/%h expected!=8000", sin_a, cos_a);
        end
        n_cmp++;
        if (sin_a[3:0] != 0 || cos_a[3:0] != 0 || sin_b[7:0] != 0 || cos_b[7:0] != 0) begin
          n_bad++;
          $display("FAIL R9 low bits actual=%h/%h expected low zero", sin_b, cos_b);
        end
      end
      cur = 16'(i * 40503);
      p2 = p1;
      p1 = cur;
      phase_i = cur;
      @(negedge clk);
    end

    // R7 half-turn negation
    for (int j = 0; j < 16; j++) begin
      logic [15:0] s0, c0;
      cur = 16'(j * 4099 + 17);
      push(cur, 3);
      s0 = sin_a; c0 = cos_a;
      push(cur + 16'h8000, 3);
      chk("R7 half turn sin", sin_a, 16'(16'd0 - s0));
      chk("R7 half turn cos", cos_a, 16'(16'd0 - c0));
    end

    // R3 low phase bits ignored
    for (int j = 0; j < 8; j++) begin
      logic [15:0] s0, c0;
      cur = 16'(j * 8192 + 4864);
      push({cur[15:4], 4'h0}, 3);
      s0 = sin_a; c0 = cos_a;
      low_a = {cur[15:4], 4'hF};
      push(low_a, 3);
      chk("R3 low bits sin", sin_a, s0);
      chk("R3 low bits cos", cos_a, c0);
    end

    // R5 stall
    phase_i = 16'h2000; @(negedge clk);
    phase_i = 16'h6000; @(negedge clk);
    en_i = 1'b0; phase_i = 16'h1234;
    @(negedge clk);
    chk_all("R5 stall hold", 16'h2000);
    phase_i = 16'hC321;
    @(negedge clk);
    chk_all("R5 stall hold", 16'h2000);
    en_i = 1'b1; phase_i = 16'hA000;
    @(negedge clk);
    chk_all("R5 in-flight", 16'h6000);
    @(negedge clk);
    chk_all("R5 resume", 16'hA000);

    // R6 asynchronous reset mid-run
    push(16'h4000, 3);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R6 async sin", sin_a, 16'h0000);
    chk("R6 async cos8", cos_b, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule